// File: doc/BRIEF.md
# Redundant Store Release Checker

This block sits where stores leave a pair of redundant execution threads and enter the data cache. The leading thread commits its stores first. Each one is parked in a small in-order buffer as an address/data pair, and nothing reaches memory at that point. When the trailing thread later commits its copy of the same store, the block compares that copy against the oldest parked entry. A full match releases exactly one write on the cache port. Any difference in address or data raises a fault that stays set until reset, and the pair is dropped without a write.

Flow control works on both sides. Leading stores are held off while the buffer is full. A trailing store waits while there is nothing to compare it with, or while the previous write is still waiting at the cache port. The trailing side never depends on the leading side. A full buffer therefore cannot stop the trailing thread from draining it.

Top module: `dual_store_validator`

## Requirements
- R1: After reset, `wr_valid` and `fault` are 0, `lead_ready` is 1 and `trail_ready` is 0.
- R2: A store accepted from the leading thread never causes a cache write by itself. `wr_valid` rises only in the cycle after a trailing store is accepted.
- R3: `lead_ready` is 1 while fewer than DEPTH leading stores are held, and 0 once DEPTH are held. A store offered while `lead_ready` is 0 is not stored.
- R4: While no leading store is held, `trail_ready` is 0 and a pending trailing store waits without effect.
- R5: A trailing store whose address and data both equal the oldest held entry produces exactly one write. In the cycle after acceptance, `wr_valid` is 1 and `wr_addr`/`wr_data` carry that pair.
- R6: Trailing stores are matched in order, each against the oldest entry not yet consumed, and writes leave in that same order.
- R7: A trailing store that differs from the oldest entry in address or data sets `fault` in the next cycle. It consumes that entry and produces no write.
- R8: Once set, `fault` stays 1 until reset. Later matching pairs are still written.
- R9: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R10: With at least one entry held and the write port free (`wr_valid` 0 or `wr_ready` 1), `trail_ready` is 1. This holds even when the buffer is full.
- R11: While `wr_valid` is 1 and `wr_ready` is 0, `trail_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lead_valid | input | 1 | Leading thread offers a committed store |
| lead_ready | output | 1 | Buffer has room for a leading store |
| lead_addr | input | AW | Leading store address |
| lead_data | input | DW | Leading store data |
| trail_valid | input | 1 | Trailing thread offers its committed store |
| trail_ready | output | 1 | Trailing store can be compared now |
| trail_addr | input | AW | Trailing store address |
| trail_data | input | DW | Trailing store data |
| wr_valid | output | 1 | Validated store is presented to the data cache |
| wr_ready | input | 1 | Data cache takes the presented store |
| wr_addr | output | AW | Validated store address |
| wr_data | output | DW | Validated store data |
| fault | output | 1 | Sticky redundancy mismatch flag |

## Verification
The hardest case to reach is a mismatch deep in a full buffer, followed by further traffic. A fault at the first entry says little about the entries queued behind it. The bench fills the buffer to DEPTH for each possible mismatch position, once with a corrupted address and once with corrupted data. It checks that exactly that pair is dropped, that the other pairs are written in order, and that the fault rises at exactly that point and stays set. A stalled write port with entries still queued is created by holding `wr_ready` low after a match. This shows that the trailing side waits and the presented write stays frozen.

// File: rtl/dsv_pkg.sv
`timescale 1ns/1ps
package dsv_pkg;
  // Outcome of presenting one trailing store to the comparator
  typedef enum logic [1:0] {
    CMP_NONE  = 2'd0,
    CMP_MATCH = 2'd1,
    CMP_DIFF  = 2'd2
  } cmp_res_e;
endpackage

// File: rtl/dsv_lead_fifo.sv
`timescale 1ns/1ps
module dsv_lead_fifo #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] occ,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data
);

  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] slot_a [DEPTH];
  logic [DW-1:0] slot_d [DEPTH];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  // next-state
  always_comb begin
    wr_d  = push ? bump(wr_q) : wr_q;
    rd_d  = pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  // pointer and count registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // one storage slot per entry, written only when selected
  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic          we;
    logic [AW-1:0] a_q;
    logic [DW-1:0] d_q;
    assign we = push && (wr_q == PW'(e));
    always_ff @(posedge clk) begin
      if (we) begin
        a_q <= push_addr;
        d_q <= push_data;
      end
    end
    assign slot_a[e] = a_q;
    assign slot_d[e] = d_q;
  end

  assign head_addr = slot_a[rd_q];
  assign head_data = slot_d[rd_q];
  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign occ       = cnt_q;

endmodule

// File: rtl/dsv_compare.sv
`timescale 1ns/1ps
module dsv_compare #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              fire,
  input  logic [AW-1:0]     t_addr,
  input  logic [DW-1:0]     t_data,
  input  logic [AW-1:0]     h_addr,
  input  logic [DW-1:0]     h_data,
  output dsv_pkg::cmp_res_e res
);
  import dsv_pkg::*;

  logic addr_eq, data_eq;

  always_comb begin
    addr_eq = ~|(t_addr ^ h_addr);
    data_eq = ~|(t_data ^ h_data);
    if (!fire)                 res = CMP_NONE;
    else if (addr_eq && data_eq) res = CMP_MATCH;
    else                       res = CMP_DIFF;
  end

endmodule

// File: rtl/dsv_release.sv
`timescale 1ns/1ps
module dsv_release #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dsv_pkg::cmp_res_e res,
  input  logic [AW-1:0]     res_addr,
  input  logic [DW-1:0]     res_data,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_data,
  output logic              fault,
  output logic              slot_free
);
  import dsv_pkg::*;

  logic          vld_q, vld_d;
  logic          flt_q, flt_d;
  logic          load_en;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  // next-state
  always_comb begin
    load_en = (res == CMP_MATCH);
    vld_d   = vld_q;
    if (vld_q && mem_ready) vld_d = 1'b0;
    if (load_en)            vld_d = 1'b1;
    flt_d   = flt_q | (res == CMP_DIFF);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      flt_q <= flt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (load_en) begin
      addr_q <= res_addr;
      data_q <= res_data;
    end
  end

  assign mem_valid = vld_q;
  assign mem_addr  = addr_q;
  assign mem_data  = data_q;
  assign fault     = flt_q;
  assign slot_free = !vld_q || mem_ready;

endmodule

// File: rtl/dual_store_validator.sv
`timescale 1ns/1ps
module dual_store_validator #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lead_valid,
  output logic          lead_ready,
  input  logic [AW-1:0] lead_addr,
  input  logic [DW-1:0] lead_data,
  input  logic          trail_valid,
  output logic          trail_ready,
  input  logic [AW-1:0] trail_addr,
  input  logic [DW-1:0] trail_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          fault
);
  import dsv_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  logic          buf_full, buf_empty, slot_free;
  logic          lead_fire, trail_fire;
  logic [CW-1:0] occ;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;
  cmp_res_e      res;

  assign lead_ready  = !buf_full;
  assign lead_fire   = lead_valid && lead_ready;
  // trailing side depends only on held entries and the write port
  assign trail_ready = !buf_empty && slot_free;
  assign trail_fire  = trail_valid && trail_ready;

  dsv_lead_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (lead_fire),
    .push_addr (lead_addr),
    .push_data (lead_data),
    .pop       (trail_fire),
    .full      (buf_full),
    .empty     (buf_empty),
    .occ       (occ),
    .head_addr (head_addr),
    .head_data (head_data)
  );

  dsv_compare #(.AW(AW), .DW(DW)) u_cmp (
    .fire   (trail_fire),
    .t_addr (trail_addr),
    .t_data (trail_data),
    .h_addr (head_addr),
    .h_data (head_data),
    .res    (res)
  );

  dsv_release #(.AW(AW), .DW(DW)) u_rel (
    .clk       (clk),
    .rst_n     (rst_n),
    .res       (res),
    .res_addr  (head_addr),
    .res_data  (head_data),
    .mem_ready (wr_ready),
    .mem_valid (wr_valid),
    .mem_addr  (wr_addr),
    .mem_data  (wr_data),
    .fault     (fault),
    .slot_free (slot_free)
  );

endmodule

// File: rtl/dsv_checker.sv
`timescale 1ns/1ps
module dsv_checker #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lead_valid,
  input logic          lead_ready,
  input logic          trail_valid,
  input logic          trail_ready,
  input logic [AW-1:0] trail_addr,
  input logic [DW-1:0] trail_data,
  input logic [AW-1:0] head_addr,
  input logic [DW-1:0] head_data,
  input logic [CW-1:0] occ,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          fault
);

  p_write_needs_trail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(trail_valid && trail_ready));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_valid && lead_ready) |-> (occ < CW'(DEPTH)));

  p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lead_ready |-> (occ == CW'(DEPTH)));

  p_empty_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !trail_ready);

  p_match_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_valid && trail_ready && trail_addr == head_addr && trail_data == head_data)
    |=> (wr_valid && wr_addr == $past(trail_addr) && wr_data == $past(trail_data)));

  p_diff_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_valid && trail_ready && (trail_addr != head_addr || trail_data != head_data))
    |=> (fault && !wr_valid));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  p_progress_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((occ != '0) && (!wr_valid || wr_ready)) |-> trail_ready);

  p_stall_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> !trail_ready);

endmodule

bind dual_store_validator dsv_checker #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lead_valid  (lead_valid),
  .lead_ready  (lead_ready),
  .trail_valid (trail_valid),
  .trail_ready (trail_ready),
  .trail_addr  (trail_addr),
  .trail_data  (trail_data),
  .head_addr   (head_addr),
  .head_data   (head_data),
  .occ         (occ),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .fault       (fault)
);

// File: tb/dual_store_validator_tb_top.sv
`timescale 1ns/1ps
module dual_store_validator_tb_top;
  localparam int AW = 8, DW = 8, DEPTH = 4;

  logic          clk, rst_n;
  logic          lead_valid, lead_ready, trail_valid, trail_ready;
  logic [AW-1:0] lead_addr, trail_addr, wr_addr;
  logic [DW-1:0] lead_data, trail_data, wr_data;
  logic          wr_valid, wr_ready, fault;

  int checks = 0, fails = 0, log_n = 0;
  logic [AW-1:0] log_a [64];
  logic [DW-1:0] log_d [64];

  dual_store_validator #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut_i (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // record every write handshake, sampled well after the falling edge
  always @(negedge clk) begin
    #2;
    if (rst_n && wr_valid && wr_ready) begin
      if (log_n < 64) begin
        log_a[log_n] = wr_addr;
        log_d[log_n] = wr_data;
      end
      log_n++;
    end
  end

  function automatic logic [7:0] fa(int n, int i);
    return 8'(n * 16 + i * 3 + 1);
  endfunction
  function automatic logic [7:0] fd(int n, int i);
    return 8'(int'(fa(n, i)) * 5 + 7);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lead_valid = 1'b0; trail_valid = 1'b0; wr_ready = 1'b1;
    lead_addr = '0; lead_data = '0; trail_addr = '0; trail_data = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic lead(logic [AW-1:0] a, logic [DW-1:0] d, output bit took);
    @(negedge clk);
    lead_valid = 1'b1; lead_addr = a; lead_data = d;
    #1 took = lead_ready;
    @(posedge clk);
    #1 lead_valid = 1'b0;
  endtask

  task automatic trail(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    trail_valid = 1'b1; trail_addr = a; trail_data = d;
    #1;
    while (!trail_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 trail_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    #3;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit took;
    int base;
    rst_n = 1'b0;
    do_reset();
    #1;
    // R1 reset state
    chk(wr_valid == 1'b0, "R1 wr_valid", int'(wr_valid), 0);
    chk(fault == 1'b0, "R1 fault", int'(fault), 0);
    chk(lead_ready == 1'b1, "R1 lead_ready", int'(lead_ready), 1);
    chk(trail_ready == 1'b0, "R1 trail_ready", int'(trail_ready), 0);

    // R4: trailing store with empty buffer waits
    base = log_n;
    trail_valid = 1'b1; trail_addr = 8'h33; trail_data = 8'h44;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(trail_ready == 1'b0, "R4 trail_ready empty", int'(trail_ready), 0);
    end
    trail_valid = 1'b0;
    settle();
    chk(log_n == base, "R4 no write", log_n - base, 0);
    chk(fault == 1'b0, "R4 no fault", int'(fault), 0);

    // sweep of buffer fill levels
    for (int n = 1; n <= DEPTH; n++) begin
      base = log_n;
      for (int i = 0; i < n; i++) begin
        lead(fa(n, i), fd(n, i), took);
        chk(took, "R3 accepted below depth", int'(took), 1);
      end
      settle();
      chk(lead_ready == (n < DEPTH), "R3 lead_ready level", int'(lead_ready), int'(n < DEPTH));
      chk(log_n == base && !wr_valid, "R2 no write from lead", log_n - base, 0);
      if (n == DEPTH) begin
        chk(trail_ready == 1'b1, "R10 trail_ready when full", int'(trail_ready), 1);
        lead(8'hEE, 8'hEE, took);
        chk(!took, "R3 refused when full", int'(took), 0);
      end
      for (int i = 0; i < n; i++) trail(fa(n, i), fd(n, i));
      settle();
      chk(log_n == base + n, "R5 one write per pair", log_n - base, n);
      for (int i = 0; i < n; i++)
        chk(log_a[base+i] == fa(n, i) && log_d[base+i] == fd(n, i), "R6 order",
            int'(log_a[base+i]), int'(fa(n, i)));
      chk(fault == 1'b0, "R5 no fault on match", int'(fault), 0);
    end

    // R9/R11: stalled write port
    base = log_n;
    lead(fa(7, 0), fd(7, 0), took);
    lead(fa(7, 1), fd(7, 1), took);
    @(negedge clk); wr_ready = 1'b0;
    trail(fa(7, 0), fd(7, 0));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(wr_valid && wr_addr == fa(7, 0) && wr_data == fd(7, 0), "R9 held",
          int'(wr_addr), int'(fa(7, 0)));
      chk(trail_ready == 1'b0, "R11 trail stalled", int'(trail_ready), 0);
    end
    @(negedge clk); wr_ready = 1'b1;
    settle();
    chk(log_n == base + 1 && log_a[base] == fa(7, 0), "R9 single drain", log_n - base, 1);
    trail(fa(7, 1), fd(7, 1));
    settle();
    chk(log_n == base + 2 && log_d[base+1] == fd(7, 1), "R5 second write", log_n - base, 2);

    // R7/R8: mismatch at every position, on address and on data
    for (int mode = 0; mode < 2; mode++) begin
      for (int k = 0; k < DEPTH; k++) begin
        do_reset();
        base = log_n;
        for (int i = 0; i < DEPTH; i++) lead(fa(9 + mode, i), fd(9 + mode, i), took);
        for (int i = 0; i < DEPTH; i++) begin
          logic [AW-1:0] a;
          logic [DW-1:0] d;
          a = fa(9 + mode, i);
          d = fd(9 + mode, i);
          if (i == k) begin
            if (mode == 0) a = a ^ 8'h80;
            else           d = d ^ 8'h01;
          end
          trail(a, d);
          chk(fault == (i >= k), "R7 fault timing", int'(fault), int'(i >= k));
        end
        settle();
        chk(log_n == base + DEPTH - 1, "R7 pair dropped", log_n - base, DEPTH - 1);
        for (int i = 0, j = 0; i < DEPTH; i++) begin
          if (i != k) begin
            chk(log_a[base+j] == fa(9 + mode, i) && log_d[base+j] == fd(9 + mode, i),
                "R7 others written", int'(log_a[base+j]), int'(fa(9 + mode, i)));
            j++;
          end
        end
        lead(8'h5A, 8'hA5, took);
        trail(8'h5A, 8'hA5);
        settle();
        chk(log_n == base + DEPTH && log_a[base+DEPTH-1] == 8'h5A, "R8 writes continue",
            log_n - base, DEPTH);
        chk(fault == 1'b1, "R8 sticky", int'(fault), 1);
      end
    end

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule